// File: doc/BRIEF.md
# Two-Dimensional DMA Transfer Sequencer

This block is the transfer engine of a single DMA channel. A load pulse captures a job: source and destination start addresses, the number of elements in a frame, the number of frames, a packet length and, for each side, an addressing mode with its element and frame index values. The sequencer turns each side's mode into a per-element address step and an extra per-frame step. It then moves the job one element at a time, one element for each transfer slot it is granted.

Each element is a read request on a memory port, followed by the read response and then a write request. With constant fill, the read is skipped and a programmed colour word is written instead. With transparent copy, the write is dropped whenever the element equals the colour word. As elements move, the engine raises sticky completion flags for half frame, last frame, end of frame, end of block and end of packet. Each flag is gated by its own enable bit. A status-clear pulse empties the flags.

The request channel (`mreq_*`) and the read-response channel (`rsp_*`) are both valid/ready. Back-pressure works as follows. Once `mreq_valid` is high, it stays high, and address, direction, size and write data stay fixed until `mreq_ready` is sampled high. `rsp_ready` is high only while the engine waits for read data. The engine changes its counters and addresses only on a completed handshake. Job set-up, grant, busy, error and status pins are plain levels.

Top module: `dma2d_seq`

## Requirements
- R1: A `load` pulse is taken only while `busy` is low; a pulse while busy changes nothing. A load with zero elements or zero frames sets `bad_req`, leaves `busy` low and issues no request. A valid load clears `bad_req` and raises `busy` on the next cycle.
- R2: Addressing mode codes are 0 constant, 1 post-increment, 2 single-index and 3 double-index. Element size codes are 0 = 1 byte, 1 = 2 bytes and 2 or 3 = 4 bytes. Constant mode has zero element and frame steps. Post-increment mode steps by the element size and has a zero frame step.
- R3: Single-index mode steps each element by size + element index − 1, with a zero frame step. Double-index mode uses the same element step and adds frame index − element index at each frame end. Indices are signed 16-bit values.
- R4: With `cfg_legacy` high, both sides take the source element and frame indices. Otherwise each side uses its own indices.
- R5: Elements are moved frame by frame. After the last element of a frame, the element count returns to 0 and both addresses also add their frame step. `busy` falls on the cycle after the last element of the last frame completes.
- R6: A request holds `mreq_valid`, `mreq_addr`, `mreq_write` and `mreq_wdata` stable until `mreq_ready`. Write data is masked to the element size.
- R7: An element starts only in a cycle where `xfer_grant` is high. While the grant stays low, no request is issued.
- R8: With constant fill, no read request is issued and the colour word (masked to the element size) is written.
- R9: With transparent copy, an element whose size-masked value equals the size-masked colour is not written, but the addresses and counters still advance.
- R10: Flag bit positions are half frame 2, end frame 3, last frame 4 and end block 5. Half frame is set when the in-frame count after a move equals elements/2 (rounded down). Last frame is set on the first element of the final frame. End frame is set on each frame end, and end block on the final one.
- R11: With `cfg_pkt_mode` high, a packet count runs across frame borders and wraps at `cfg_pkt_len`. On each wrap, the end-of-packet flag (bit 7) is set, but only when `cfg_dst_sync` is high.
- R12: A flag is set only if its `flag_en` bit is high. Flags stay set until `status_clr`. When a set and a clear land in the same cycle, the set wins. Bits 0, 1, 6, 8 to 11 stay 0.
- R13: After reset, `busy`, `bad_req`, `status`, `mreq_valid` and `rsp_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture a new job (ignored while busy) |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_elem_cnt | input | EW | Elements per frame |
| cfg_frame_cnt | input | FW | Frames per block |
| cfg_pkt_len | input | PW | Elements per packet |
| cfg_src_mode | input | 2 | Source addressing mode |
| cfg_dst_mode | input | 2 | Destination addressing mode |
| cfg_elem_size | input | 2 | Element size code |
| cfg_src_eidx | input | IW | Source element index (signed) |
| cfg_src_fidx | input | IW | Source frame index (signed) |
| cfg_dst_eidx | input | IW | Destination element index (signed) |
| cfg_dst_fidx | input | IW | Destination frame index (signed) |
| cfg_legacy | input | 1 | Both sides use source indices |
| cfg_pkt_mode | input | 1 | Enable packet counting |
| cfg_dst_sync | input | 1 | Channel is destination-synchronised |
| cfg_const_fill | input | 1 | Write colour word, skip reads |
| cfg_transp | input | 1 | Drop writes equal to colour word |
| cfg_color | input | DW | Colour word |
| xfer_grant | input | 1 | Transfer slot granted this cycle |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_addr | output | AW | Request byte address |
| mreq_size | output | 2 | Element size code of the request |
| mreq_wdata | output | DW | Write data, masked to size |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Engine waits for read data |
| rsp_data | input | DW | Read data |
| busy | output | 1 | Job in progress |
| bad_req | output | 1 | Last load was rejected |
| flag_en | input | 12 | Per-flag enables |
| status_clr | input | 1 | Clear all flags |
| status | output | 12 | Sticky flags |

## Verification
A status clear and a flag set can fall on the same clock edge. The bench provokes this by holding `status_clr` high through a whole block and dropping it on the first cycle after `busy` falls. Only the flags raised by the final element may remain, and the bench compares them with a model of that last move. A load pulse in the middle of a block can also meet element traffic. It is judged by the written address/data stream, which must still match the original job exactly.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    AM_CONST   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_SINGLE  = 2'd2,
    AM_DOUBLE  = 2'd3
  } addr_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_RD,
    SQ_RSP,
    SQ_WR
  } seq_state_e;

  localparam int ST_W     = 12;
  localparam int FB_HALF  = 2;
  localparam int FB_FRAME = 3;
  localparam int FB_LAST  = 4;
  localparam int FB_BLOCK = 5;
  localparam int FB_PKT   = 7;

  typedef struct packed {
    logic half;
    logic frame_end;
    logic last;
    logic block_end;
    logic pkt;
  } elem_evt_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_step.sv
module dma2d_step
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  addr_mode_e        mode,
  input  logic [2:0]        size_b,
  input  logic [IW-1:0]     eidx,
  input  logic [IW-1:0]     fidx,
  output logic [AW-1:0]     elem_step,
  output logic [AW-1:0]     frame_step
);

  logic [AW-1:0] e_ext;
  logic [AW-1:0] f_ext;
  logic [AW-1:0] sz_ext;
  logic [AW-1:0] idx_step;
  logic [AW-1:0] jump;

  assign e_ext    = {{(AW-IW){eidx[IW-1]}}, eidx};
  assign f_ext    = {{(AW-IW){fidx[IW-1]}}, fidx};
  assign sz_ext   = {{(AW-3){1'b0}}, size_b};
  assign idx_step = sz_ext + e_ext - AW'(1);
  assign jump     = f_ext - e_ext;

  always_comb begin
    elem_step  = '0;
    frame_step = '0;
    case (mode)
      AM_CONST: begin
        elem_step  = '0;
        frame_step = '0;
      end
      AM_POSTINC: begin
        elem_step  = sz_ext;
        frame_step = '0;
      end
      AM_SINGLE: begin
        elem_step  = idx_step;
        frame_step = '0;
      end
      default: begin
        elem_step  = idx_step;
        frame_step = jump;
      end
    endcase
  end

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] elem_step,
  input  logic [AW-1:0] frame_step,
  input  logic          adv,
  input  logic          frame_end,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] extra;

  assign extra = frame_end ? frame_step : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= start;
    else if (adv)
      addr <= addr + elem_step + extra;
  end

endmodule

// File: rtl/dma2d_count.sv
module dma2d_count
  import dma2d_pkg::*;
#(
  parameter int EW = 16,
  parameter int FW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [EW-1:0] elem_cnt,
  input  logic [FW-1:0] frame_cnt,
  input  logic [PW-1:0] pkt_len,
  input  logic          pkt_mode,
  input  logic          adv,
  output elem_evt_t     evt
);

  logic [EW-1:0] e_lim, e_idx, e_nx;
  logic [FW-1:0] f_lim, f_idx;
  logic [PW-1:0] p_lim, p_idx, p_nx;
  logic          pm_q;
  logic          last_f;

  assign e_nx   = e_idx + EW'(1);
  assign p_nx   = p_idx + PW'(1);
  assign last_f = (f_idx == f_lim - FW'(1));

  always_comb begin
    evt.frame_end = (e_nx == e_lim);
    evt.block_end = evt.frame_end && last_f;
    evt.half      = (e_nx == (e_lim >> 1));
    evt.last      = (e_nx == EW'(1)) && last_f;
    evt.pkt       = pm_q && (p_nx == p_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lim <= '0;
      f_lim <= '0;
      p_lim <= '0;
      pm_q  <= 1'b0;
      e_idx <= '0;
      f_idx <= '0;
      p_idx <= '0;
    end else if (load) begin
      e_lim <= elem_cnt;
      f_lim <= frame_cnt;
      p_lim <= pkt_len;
      pm_q  <= pkt_mode;
      e_idx <= '0;
      f_idx <= '0;
      p_idx <= '0;
    end else if (adv) begin
      e_idx <= evt.frame_end ? '0 : e_nx;
      if (evt.block_end)
        f_idx <= '0;
      else if (evt.frame_end)
        f_idx <= f_idx + FW'(1);
      if (evt.pkt)
        p_idx <= '0;
      else if (pm_q)
        p_idx <= p_nx;
    end
  end

  // R5: the in-frame and frame counts never leave the loaded range
  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_lim != '0 && f_lim != '0) |-> (e_idx < e_lim && f_idx < f_lim));

endmodule

// File: rtl/dma2d_status.sv
module dma2d_status
  import dma2d_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] en,
  input  logic            clr,
  output logic [ST_W-1:0] status
);

  logic [ST_W-1:0] gated;
  logic [ST_W-1:0] kept;

  assign gated = set_vec & en;
  assign kept  = clr ? '0 : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else
      status <= kept | gated;
  end

  // R12: a newly risen flag must have had its enable high
  p_flag_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(en)) == '0));

  // R12: a clear with nothing to set empties the register
  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && gated == '0) |=> (status == '0));

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int EW = 16,
  parameter int FW = 16,
  parameter int PW = 16,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   cfg_src_addr,
  input  logic [AW-1:0]   cfg_dst_addr,
  input  logic [EW-1:0]   cfg_elem_cnt,
  input  logic [FW-1:0]   cfg_frame_cnt,
  input  logic [PW-1:0]   cfg_pkt_len,
  input  logic [1:0]      cfg_src_mode,
  input  logic [1:0]      cfg_dst_mode,
  input  logic [1:0]      cfg_elem_size,
  input  logic [IW-1:0]   cfg_src_eidx,
  input  logic [IW-1:0]   cfg_src_fidx,
  input  logic [IW-1:0]   cfg_dst_eidx,
  input  logic [IW-1:0]   cfg_dst_fidx,
  input  logic            cfg_legacy,
  input  logic            cfg_pkt_mode,
  input  logic            cfg_dst_sync,
  input  logic            cfg_const_fill,
  input  logic            cfg_transp,
  input  logic [DW-1:0]   cfg_color,
  input  logic            xfer_grant,
  output logic            mreq_valid,
  input  logic            mreq_ready,
  output logic            mreq_write,
  output logic [AW-1:0]   mreq_addr,
  output logic [1:0]      mreq_size,
  output logic [DW-1:0]   mreq_wdata,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [DW-1:0]   rsp_data,
  output logic            busy,
  output logic            bad_req,
  input  logic [ST_W-1:0] flag_en,
  input  logic            status_clr,
  output logic [ST_W-1:0] status
);

  localparam int NSIDE = 2;

  seq_state_e    state, state_nx;
  logic          load_ok;
  logic          adv;
  logic          skip_rsp;
  logic [DW-1:0] data_mask;
  logic [DW-1:0] data_q;
  elem_evt_t     evt;
  logic [ST_W-1:0] set_vec;

  // latched job
  logic [1:0]    mode_q   [NSIDE];
  logic [IW-1:0] eidx_q   [NSIDE];
  logic [IW-1:0] fidx_q   [NSIDE];
  logic [1:0]    size_q;
  logic          legacy_q, dst_sync_q, const_q, transp_q;
  logic [DW-1:0] color_q;

  // per-side address path
  logic [AW-1:0] start_in [NSIDE];
  logic [AW-1:0] cur_addr [NSIDE];

  assign load_ok = load && (state == SQ_IDLE) &&
                   (cfg_elem_cnt != '0) && (cfg_frame_cnt != '0);

  assign start_in[0] = cfg_src_addr;
  assign start_in[1] = cfg_dst_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q[0]  <= '0;
      mode_q[1]  <= '0;
      eidx_q[0]  <= '0;
      eidx_q[1]  <= '0;
      fidx_q[0]  <= '0;
      fidx_q[1]  <= '0;
      size_q     <= '0;
      legacy_q   <= 1'b0;
      dst_sync_q <= 1'b0;
      const_q    <= 1'b0;
      transp_q   <= 1'b0;
      color_q    <= '0;
    end else if (load_ok) begin
      mode_q[0]  <= cfg_src_mode;
      mode_q[1]  <= cfg_dst_mode;
      eidx_q[0]  <= cfg_src_eidx;
      eidx_q[1]  <= cfg_dst_eidx;
      fidx_q[0]  <= cfg_src_fidx;
      fidx_q[1]  <= cfg_dst_fidx;
      size_q     <= cfg_elem_size;
      legacy_q   <= cfg_legacy;
      dst_sync_q <= cfg_dst_sync;
      const_q    <= cfg_const_fill;
      transp_q   <= cfg_transp;
      color_q    <= cfg_color;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bad_req <= 1'b0;
    else if (load && state == SQ_IDLE)
      bad_req <= (cfg_elem_cnt == '0) || (cfg_frame_cnt == '0);
  end

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      logic [IW-1:0] e_sel, f_sel;
      logic [AW-1:0] es, fs;

      if (s == 0) begin : g_src_idx
        assign e_sel = eidx_q[0];
        assign f_sel = fidx_q[0];
      end else begin : g_oth_idx
        assign e_sel = legacy_q ? eidx_q[0] : eidx_q[s];
        assign f_sel = legacy_q ? fidx_q[0] : fidx_q[s];
      end

      dma2d_step #(.AW(AW), .IW(IW)) u_step (
        .mode       (addr_mode_e'(mode_q[s])),
        .size_b     (size_bytes(size_q)),
        .eidx       (e_sel),
        .fidx       (f_sel),
        .elem_step  (es),
        .frame_step (fs)
      );

      dma2d_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ok),
        .start      (start_in[s]),
        .elem_step  (es),
        .frame_step (fs),
        .adv        (adv),
        .frame_end  (evt.frame_end),
        .addr       (cur_addr[s])
      );
    end
  endgenerate

  dma2d_count #(.EW(EW), .FW(FW), .PW(PW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ok),
    .elem_cnt  (cfg_elem_cnt),
    .frame_cnt (cfg_frame_cnt),
    .pkt_len   (cfg_pkt_len),
    .pkt_mode  (cfg_pkt_mode),
    .adv       (adv),
    .evt       (evt)
  );

  // element data path
  always_comb begin
    case (size_q)
      2'd0:    data_mask = DW'(8'hFF);
      2'd1:    data_mask = DW'(16'hFFFF);
      default: data_mask = '1;
    endcase
  end

  assign skip_rsp = transp_q && ((rsp_data & data_mask) == (color_q & data_mask));

  always_comb begin
    adv = 1'b0;
    case (state)
      SQ_WAIT: adv = xfer_grant && const_q && transp_q;
      SQ_RSP:  adv = rsp_valid && skip_rsp;
      SQ_WR:   adv = mreq_ready;
      default: adv = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      SQ_IDLE: if (load_ok) state_nx = SQ_WAIT;
      SQ_WAIT: begin
        if (xfer_grant) begin
          if (!const_q)      state_nx = SQ_RD;
          else if (!transp_q) state_nx = SQ_WR;
        end
      end
      SQ_RD:   if (mreq_ready) state_nx = SQ_RSP;
      SQ_RSP:  if (rsp_valid && !skip_rsp) state_nx = SQ_WR;
      default: state_nx = state;
    endcase
    if (adv)
      state_nx = evt.block_end ? SQ_IDLE : SQ_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= SQ_IDLE;
    else
      state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (state == SQ_WAIT && xfer_grant && const_q)
      data_q <= color_q;
    else if (state == SQ_RSP && rsp_valid)
      data_q <= rsp_data;
  end

  assign mreq_valid = (state == SQ_RD) || (state == SQ_WR);
  assign mreq_write = (state == SQ_WR);
  assign mreq_addr  = (state == SQ_WR) ? cur_addr[1] : cur_addr[0];
  assign mreq_size  = size_q;
  assign mreq_wdata = data_q & data_mask;
  assign rsp_ready  = (state == SQ_RSP);
  assign busy       = (state != SQ_IDLE);

  always_comb begin
    set_vec = '0;
    if (adv) begin
      set_vec[FB_HALF]  = evt.half;
      set_vec[FB_FRAME] = evt.frame_end;
      set_vec[FB_LAST]  = evt.last;
      set_vec[FB_BLOCK] = evt.block_end;
      set_vec[FB_PKT]   = evt.pkt && dst_sync_q;
    end
  end

  dma2d_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .en      (flag_en),
    .clr     (status_clr),
    .status  (status)
  );

  // R6: a stalled request keeps its fields
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=>
      (mreq_valid && $stable(mreq_addr) && $stable(mreq_write) && $stable(mreq_wdata)));

  // R1: a rejected load leaves the engine idle and flags the error
  p_bad_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy && (cfg_elem_cnt == '0 || cfg_frame_cnt == '0)) |=> (!busy && bad_req));

  // R8: constant fill never reads
  p_fill_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (const_q && mreq_valid) |-> mreq_write);

  // R9: a colour-matching element is not followed by a write
  p_skip_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_valid && skip_rsp) |=> !mreq_valid);

  // R7: no request starts without a grant
  p_grant_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && !xfer_grant) |=> !mreq_valid);

endmodule

// File: tb/dma2d_seq_bench.sv
`timescale 1ns/1ps
module dma2d_seq_bench;
  localparam int AW = 32, DW = 32, EW = 16, FW = 16, PW = 16, IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          load = 0;
  logic [AW-1:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [EW-1:0] cfg_elem_cnt = 0;
  logic [FW-1:0] cfg_frame_cnt = 0;
  logic [PW-1:0] cfg_pkt_len = 0;
  logic [1:0]    cfg_src_mode = 0, cfg_dst_mode = 0, cfg_elem_size = 0;
  logic [IW-1:0] cfg_src_eidx = 0, cfg_src_fidx = 0, cfg_dst_eidx = 0, cfg_dst_fidx = 0;
  logic          cfg_legacy = 0, cfg_pkt_mode = 0, cfg_dst_sync = 0;
  logic          cfg_const_fill = 0, cfg_transp = 0;
  logic [DW-1:0] cfg_color = 0;
  logic          xfer_grant = 0, mreq_ready = 0, rsp_valid = 0;
  logic [DW-1:0] rsp_data = 0;
  logic [11:0]   flag_en = 12'hFFF;
  logic          status_clr = 0;
  logic          mreq_valid, mreq_write, rsp_ready, busy, bad_req;
  logic [AW-1:0] mreq_addr;
  logic [1:0]    mreq_size;
  logic [DW-1:0] mreq_wdata;
  logic [11:0]   status;

  dma2d_seq u_dma2d_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt), .cfg_pkt_len(cfg_pkt_len),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_elem_size(cfg_elem_size),
    .cfg_src_eidx(cfg_src_eidx), .cfg_src_fidx(cfg_src_fidx),
    .cfg_dst_eidx(cfg_dst_eidx), .cfg_dst_fidx(cfg_dst_fidx),
    .cfg_legacy(cfg_legacy), .cfg_pkt_mode(cfg_pkt_mode), .cfg_dst_sync(cfg_dst_sync),
    .cfg_const_fill(cfg_const_fill), .cfg_transp(cfg_transp), .cfg_color(cfg_color),
    .xfer_grant(xfer_grant),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_size(mreq_size), .mreq_wdata(mreq_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .bad_req(bad_req), .flag_en(flag_en), .status_clr(status_clr),
    .status(status)
  );

  int n_chk = 0, n_fail = 0;
  int cyc_total = 0;

  // memory-side model state
  logic [AW-1:0] cap_addr [64];
  logic [DW-1:0] cap_data [64];
  int            cap_n = 0, rd_count = 0;
  bit            hold_err = 0;
  bit            ready_rand = 1;
  int            grant_mode = 2;   // 0 low, 1 high, 2 random

  logic [AW-1:0] exp_addr [64];
  logic [DW-1:0] exp_data [64];
  int            exp_n;
  logic [11:0]   exp_all, exp_last;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] c);
    return (c == 2'd0) ? 32'hFF : (c == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 32'd1 : (c == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] estep(input logic [1:0] m, input logic [1:0] sz, input logic [15:0] ei);
    if (m == 2'd0) return 32'd0;
    if (m == 2'd1) return nbytes(sz);
    return nbytes(sz) + sx(ei) - 32'd1;
  endfunction

  function automatic logic [31:0] fstep(input logic [1:0] m, input logic [15:0] ei, input logic [15:0] fi);
    if (m == 2'd3) return sx(fi) - sx(ei);
    return 32'd0;
  endfunction

  task automatic build_expect();
    logic [31:0] sa, da, ses, sfs, des, dfs, d, msk;
    logic [15:0] dei, dfi;
    logic [11:0] b;
    int p;
    msk = size_mask(cfg_elem_size);
    dei = cfg_legacy ? cfg_src_eidx : cfg_dst_eidx;
    dfi = cfg_legacy ? cfg_src_fidx : cfg_dst_fidx;
    ses = estep(cfg_src_mode, cfg_elem_size, cfg_src_eidx);
    sfs = fstep(cfg_src_mode, cfg_src_eidx, cfg_src_fidx);
    des = estep(cfg_dst_mode, cfg_elem_size, dei);
    dfs = fstep(cfg_dst_mode, dei, dfi);
    sa = cfg_src_addr; da = cfg_dst_addr;
    exp_n = 0; exp_all = 0; exp_last = 0; p = 0;
    for (int f = 0; f < int'(cfg_frame_cnt); f++) begin
      for (int e = 0; e < int'(cfg_elem_cnt); e++) begin
        d = (cfg_const_fill ? cfg_color : mem_rd(sa)) & msk;
        if (!(cfg_transp && d == (cfg_color & msk))) begin
          exp_addr[exp_n] = da; exp_data[exp_n] = d; exp_n++;
        end
        sa = sa + ses; da = da + des;
        b = 0;
        if (e + 1 == int'(cfg_elem_cnt >> 1)) b[2] = 1'b1;
        if (e + 1 == 1 && f == int'(cfg_frame_cnt) - 1) b[4] = 1'b1;
        if (cfg_pkt_mode) begin
          p++;
          if (p == int'(cfg_pkt_len)) begin
            p = 0;
            if (cfg_dst_sync) b[7] = 1'b1;
          end
        end
        if (e + 1 == int'(cfg_elem_cnt)) begin
          b[3] = 1'b1;
          sa = sa + sfs; da = da + dfs;
          if (f == int'(cfg_frame_cnt) - 1) b[5] = 1'b1;
        end
        exp_all |= b; exp_last = b;
      end
    end
  endtask

  // memory responder and grant driver, all on the falling edge
  initial begin
    bit req_hs, req_wr, rsp_hs, stall;
    logic [AW-1:0] a_prev;
    logic [DW-1:0] d_prev;
    logic [1:0]    s_prev;
    bit pend;
    int dly;
    req_hs = 0; req_wr = 0; rsp_hs = 0; stall = 0; pend = 0; dly = 0;
    a_prev = 0; d_prev = 0; s_prev = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        req_hs = 0; rsp_hs = 0; stall = 0; pend = 0;
      end else begin
        if (req_hs) begin
          if (req_wr) begin
            if (cap_n < 64) begin
              cap_addr[cap_n] = a_prev;
              cap_data[cap_n] = d_prev & size_mask(s_prev);
            end
            cap_n++;
          end else begin
            rd_count++;
            pend = 1; dly = $urandom % 3;
            rsp_data = mem_rd(a_prev);
          end
        end
        if (rsp_hs) rsp_valid = 1'b0;
        if (stall && (!mreq_valid || mreq_addr !== a_prev || mreq_write !== req_wr ||
                      mreq_wdata !== d_prev))
          hold_err = 1;
        if (pend) begin
          if (dly == 0) begin rsp_valid = 1'b1; pend = 0; end
          else dly--;
        end
        mreq_ready = ready_rand ? ($urandom % 3 != 0) : 1'b1;
        xfer_grant = (grant_mode == 0) ? 1'b0 : (grant_mode == 1) ? 1'b1 : ($urandom % 2 == 0);
        req_hs = mreq_valid && mreq_ready;
        req_wr = mreq_write;
        a_prev = mreq_addr; d_prev = mreq_wdata; s_prev = mreq_size;
        rsp_hs = rsp_valid && rsp_ready;
        stall  = mreq_valid && !mreq_ready;
      end
    end
  end

  task automatic run_block(input string tag, input bit clr_hold, input bit busy_load, input bit hold_grant);
    int cyc;
    build_expect();
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = clr_hold;
    cap_n = 0; rd_count = 0; hold_err = 0;
    grant_mode = hold_grant ? 0 : 2;
    load = 1'b1;
    @(negedge clk); load = 1'b0;
    if (hold_grant) begin
      repeat (6) @(negedge clk);
      chk("R7 no request without grant", {31'b0, mreq_valid}, 32'd0);
      chk("R7 job pending while grant low", {31'b0, busy}, 32'd1);
      grant_mode = 2;
    end
    cyc = 0;
    while (busy && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (busy_load && cyc == 2) begin
        cfg_src_addr = cfg_src_addr + 32'h400;
        cfg_dst_addr = cfg_dst_addr + 32'h400;
        load = 1'b1;
      end else load = 1'b0;
    end
    load = 1'b0;
    status_clr = 1'b0;
    if (cyc >= 4000) chk({tag, " R5 block completes"}, 32'd0, 32'd1);
    repeat (3) @(negedge clk);
    chk({tag, " R5 write count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n && i < 64; i++) begin
      chk({tag, " R5 write addr"}, cap_addr[i], exp_addr[i]);
      chk({tag, " R5 write data"}, cap_data[i], exp_data[i]);
    end
    chk({tag, " R6 stalled request held"}, {31'b0, hold_err}, 32'd0);
    chk({tag, " R12 status"}, {20'b0, status},
        {20'b0, (clr_hold ? exp_last : exp_all) & flag_en});
  endtask

  task automatic base_cfg();
    cfg_src_addr = 32'h0000_1000; cfg_dst_addr = 32'h0000_8000;
    cfg_elem_cnt = 4; cfg_frame_cnt = 3; cfg_pkt_len = 5;
    cfg_src_mode = 2'd1; cfg_dst_mode = 2'd1; cfg_elem_size = 2'd2;
    cfg_src_eidx = 0; cfg_src_fidx = 0; cfg_dst_eidx = 0; cfg_dst_fidx = 0;
    cfg_legacy = 0; cfg_pkt_mode = 0; cfg_dst_sync = 0;
    cfg_const_fill = 0; cfg_transp = 0; cfg_color = 32'h0;
    flag_en = 12'hFFF;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog act=%0d exp<150000", cyc_total);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R13 reset state
    chk("R13 busy", {31'b0, busy}, 32'd0);
    chk("R13 bad_req", {31'b0, bad_req}, 32'd0);
    chk("R13 status", {20'b0, status}, 32'd0);
    chk("R13 mreq_valid", {31'b0, mreq_valid}, 32'd0);
    chk("R13 rsp_ready", {31'b0, rsp_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 zero counts rejected
    base_cfg(); cfg_elem_cnt = 0;
    load = 1'b1; @(negedge clk); load = 1'b0;
    chk("R1 zero elements sets bad_req", {31'b0, bad_req}, 32'd1);
    chk("R1 zero elements stays idle", {31'b0, busy}, 32'd0);
    base_cfg(); cfg_frame_cnt = 0;
    load = 1'b1; @(negedge clk); load = 1'b0;
    chk("R1 zero frames sets bad_req", {31'b0, bad_req}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R1 no request after bad load", {31'b0, mreq_valid}, 32'd0);
    base_cfg();
    run_block("R2 post-increment", 0, 0, 0);
    chk("R1 good load clears bad_req", {31'b0, bad_req}, 32'd0);

    // R2 constant destination, byte size
    base_cfg(); cfg_dst_mode = 2'd0; cfg_elem_size = 2'd0; cfg_elem_cnt = 5; cfg_frame_cnt = 2;
    run_block("R2 constant dst", 0, 0, 0);

    // R3 single and double index, own indices
    base_cfg(); cfg_src_mode = 2'd2; cfg_src_eidx = 16'd3;
    cfg_dst_mode = 2'd3; cfg_dst_eidx = 16'hFFFE; cfg_dst_fidx = 16'd20; cfg_elem_size = 2'd1;
    run_block("R3 index modes", 0, 0, 0);

    // R4 legacy sharing of source indices
    base_cfg(); cfg_src_mode = 2'd3; cfg_dst_mode = 2'd3; cfg_legacy = 1;
    cfg_src_eidx = 16'd5; cfg_src_fidx = 16'd40; cfg_dst_eidx = 16'd1; cfg_dst_fidx = 16'd2;
    run_block("R4 legacy", 0, 0, 0);

    // R8 constant fill
    base_cfg(); cfg_const_fill = 1; cfg_color = 32'hCAFE_F00D; cfg_elem_size = 2'd1;
    run_block("R8 fill", 0, 0, 0);
    chk("R8 no reads with fill", rd_count, 32'd0);

    // R9 transparent copy, byte elements
    base_cfg(); cfg_transp = 1; cfg_elem_size = 2'd0; cfg_elem_cnt = 6; cfg_frame_cnt = 1;
    cfg_color = mem_rd(cfg_src_addr + 32'd2);
    run_block("R9 transparent", 0, 0, 0);
    chk("R9 at least one write dropped", {31'b0, exp_n < 6}, 32'd1);

    // R11 packets across frames, dst-synchronised and not
    base_cfg(); cfg_pkt_mode = 1; cfg_dst_sync = 1; cfg_elem_cnt = 3; cfg_pkt_len = 4;
    run_block("R11 packet dst sync", 0, 0, 0);
    chk("R11 packet flag set", {31'b0, status[7]}, 32'd1);
    base_cfg(); cfg_pkt_mode = 1; cfg_dst_sync = 0; cfg_elem_cnt = 3; cfg_pkt_len = 4;
    run_block("R11 packet src sync", 0, 0, 0);
    chk("R11 packet flag clear", {31'b0, status[7]}, 32'd0);

    // R10 single-element frames: last-frame and end-block in one move
    base_cfg(); cfg_elem_cnt = 1; cfg_frame_cnt = 1;
    run_block("R10 single element", 0, 0, 0);
    chk("R10 flags 3,4,5", {20'b0, status}, 32'h38);

    // R7 grant held low
    base_cfg();
    run_block("R7 grant gating", 0, 0, 1);

    // R1 load while busy is ignored
    base_cfg(); cfg_elem_cnt = 5;
    run_block("R1 load while busy", 0, 1, 0);

    // R12 partial enables and clear colliding with sets
    base_cfg(); flag_en = 12'h02C;
    run_block("R12 partial enables", 0, 0, 0);
    base_cfg(); cfg_pkt_mode = 1; cfg_dst_sync = 1; cfg_pkt_len = 2;
    run_block("R12 clear held through block", 1, 0, 0);
    @(negedge clk); status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    chk("R12 clear empties", {20'b0, status}, 32'd0);

    // constrained random jobs
    ready_rand = 1;
    for (int k = 0; k < 24; k++) begin
      base_cfg();
      cfg_src_addr  = 32'h0001_0000 + ($urandom % 256);
      cfg_dst_addr  = 32'h0004_0000 + ($urandom % 256);
      cfg_elem_cnt  = EW'(1 + $urandom % 6);
      cfg_frame_cnt = FW'(1 + $urandom % 4);
      cfg_pkt_len   = PW'(1 + $urandom % 5);
      cfg_src_mode  = 2'($urandom % 4);
      cfg_dst_mode  = 2'($urandom % 4);
      cfg_elem_size = 2'($urandom % 4);
      cfg_src_eidx  = IW'(int'($urandom % 10) - 3);
      cfg_src_fidx  = IW'(int'($urandom % 40) - 10);
      cfg_dst_eidx  = IW'(int'($urandom % 10) - 3);
      cfg_dst_fidx  = IW'(int'($urandom % 40) - 10);
      cfg_legacy    = ($urandom % 3 == 0);
      cfg_pkt_mode  = ($urandom % 2 == 0);
      cfg_dst_sync  = ($urandom % 2 == 0);
      cfg_const_fill = ($urandom % 5 == 0);
      cfg_transp    = ($urandom % 4 == 0);
      cfg_color     = ($urandom % 2 == 0) ? mem_rd(cfg_src_addr) : $urandom;
      flag_en       = 12'($urandom);
      ready_rand    = ($urandom % 4 != 0);
      run_block("R5 random job", ($urandom % 6 == 0), 0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule